// File: doc/BRIEF.md
# RTC Control and Status Register with Write Protection

This block is the CPU-facing control and status word of a real-time clock. It is accessed over a simple 16-bit register port. It holds the run enable, the two alarm enables, the square-wave controls, the clock-source select, the alarm and ready flags, and a key bit that guards the run enable and the trim register. Counters, comparators and dividers sit outside the block. They reach it through strobes in the slow clock domain, and they take the slow-domain copies of the enables and the trim value that this block provides.

Any write that the slow domain has to see raises a busy flag. The bus side freezes the affected bits in a hold register and flips a request toggle. The slow side synchronizes that toggle, takes the held bits and returns an acknowledge toggle. Busy drops once that acknowledge has been synchronized back. A change made while a transfer is already in flight is queued and sent in a further transfer. Slow-domain events (pre-update, update, sub-second alarm, time-of-day alarm) reach the bus domain through toggle synchronizers and set or clear the flags.

Top module: `rtc_ctl_reg`

## Requirements
- R1: After reset the control word (acc_sel = 0) reads 0x4008: busy (bit 3) and bit 14 are 1 and every other bit is 0. The trim word (acc_sel = 1) reads 0. The first transfer to the slow domain runs by itself and then clears busy.
- R2: The key bit (bit 15) is checked at the value it held before the write. While the key is 0, writes to the run bit (bit 0) and to the trim register are ignored. While the key is 1, both can be written.
- R3: Busy is set by these writes: any write with acc_sel = 2 (count), any trim write that is accepted, and any control write that changes bit 0, bit 1 (time-of-day alarm enable) or bit 2 (sub-second alarm enable). A write that does none of these leaves busy at 0.
- R4: Once set, busy stays 1 for at least two slow-clock edges. When it clears, s_run, s_sub_en, s_tod_en and s_trim hold the values last written.
- R5: The ready flag (bit 4) is set by the slow update strobe and cleared by the slow pre-update strobe. Writing 0 to bit 4 clears it. Writing 1 to bit 4 leaves it unchanged.
- R6: irq_rdy is 1 exactly when the ready flag and the ready interrupt enable (bit 5) are both 1.
- R7: Bit 14 takes the written value only when busy is 0 before the write. Bits 12 to 10 always read 0.
- R8: The alternate clock select (bit 13) takes a write only while the run bit is 0 before the write. It drives alt_clk_sel.
- R9: The sub-second alarm strobe sets bit 7 and the time-of-day alarm strobe sets bit 6. Writing 0 to either bit clears it, and writing 1 keeps it. irq_alarm = (bit 7 and bit 2) or (bit 6 and bit 1).
- R10: Each count write produces exactly one s_cnt_load pulse in the slow domain.
- R11: A change made while a transfer is outstanding is sent in a later transfer. Busy stays 1 until that transfer completes, and the slow copy ends at the final value.
- R12: Bits 9 and 8 are plain read/write bits that drive sqw_fast and sqw_en. With acc_sel = 2 the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | CPU bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low, asynchronous |
| acc_wr | input | 1 | Write strobe, one bus cycle per write |
| acc_sel | input | 2 | Register select: 0 control, 1 trim, 2 count |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the selected register |
| irq_rdy | output | 1 | Ready interrupt request |
| irq_alarm | output | 1 | Alarm interrupt request |
| alt_clk_sel | output | 1 | Clock source select for the divider |
| sqw_en | output | 1 | Square-wave output enable |
| sqw_fast | output | 1 | Square-wave rate select |
| slow_clk | input | 1 | Slow counting clock |
| slow_rst_n | input | 1 | Slow-domain reset, active low, asynchronous |
| s_pre_upd | input | 1 | Strobe, one slow cycle wide, just before a counter update |
| s_upd | input | 1 | Strobe, one slow cycle wide, after a counter update |
| s_sub_alarm | input | 1 | Sub-second alarm strobe |
| s_tod_alarm | input | 1 | Time-of-day alarm strobe |
| s_run | output | 1 | Slow-domain copy of the run bit |
| s_sub_en | output | 1 | Slow-domain copy of the sub-second alarm enable |
| s_tod_en | output | 1 | Slow-domain copy of the time-of-day alarm enable |
| s_trim | output | TRIM_W | Slow-domain copy of the trim value |
| s_cnt_load | output | 1 | One slow-cycle pulse per count write |

## Verification
The assertions assume that acc_wr is a one-cycle strobe sampled on bus_clk, and that acc_sel and acc_wdata are stable whenever the strobe is high. They also assume that the slow strobes are synchronous to slow_clk and at least a few slow cycles apart, so that no toggle flips twice before the bus side has seen it. The bench drives every bus input at the falling edge of bus_clk. It drives each slow strobe for one slow period at the falling edge of slow_clk, and then waits eight bus cycles before the next action. The bus clock runs sixteen times faster than the slow clock. All ranges stay within a single register width.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

   localparam int WORD_W = 16;

   // control word bit positions (software-visible layout)
   localparam int B_KEY    = 15;
   localparam int B_SPARE  = 14;
   localparam int B_ALTCK  = 13;
   localparam int B_SQFAST = 9;
   localparam int B_SQON   = 8;
   localparam int B_SUBF   = 7;
   localparam int B_TODF   = 6;
   localparam int B_RDYIE  = 5;
   localparam int B_RDY    = 4;
   localparam int B_BUSY   = 3;
   localparam int B_SUBEN  = 2;
   localparam int B_TODEN  = 1;
   localparam int B_RUN    = 0;

   // slow-domain event channels
   localparam int N_EV   = 4;
   localparam int EV_PRE = 0;
   localparam int EV_UPD = 1;
   localparam int EV_SUB = 2;
   localparam int EV_TOD = 3;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_TRIM  = 2'd1,
      SEL_COUNT = 2'd2
   } rtc_sel_e;

   typedef struct packed {
      logic key;
      logic spare;
      logic altck;
      logic sqfast;
      logic sqon;
      logic subf;
      logic todf;
      logic rdyie;
      logic rdy;
      logic suben;
      logic toden;
      logic run;
   } rtc_ctrl_t;

   function automatic logic [WORD_W-1:0] pack_ctrl(input rtc_ctrl_t c, input logic busy);
      logic [WORD_W-1:0] w;
      w           = '0;
      w[B_KEY]    = c.key;
      w[B_SPARE]  = c.spare;
      w[B_ALTCK]  = c.altck;
      w[B_SQFAST] = c.sqfast;
      w[B_SQON]   = c.sqon;
      w[B_SUBF]   = c.subf;
      w[B_TODF]   = c.todf;
      w[B_RDYIE]  = c.rdyie;
      w[B_RDY]    = c.rdy;
      w[B_BUSY]   = busy;
      w[B_SUBEN]  = c.suben;
      w[B_TODEN]  = c.toden;
      w[B_RUN]    = c.run;
      return w;
   endfunction

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rtc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rtc_evt_sync.sv
module rtc_evt_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         s_clk,
   input  logic         s_rst_n,
   input  logic [N-1:0] s_stb,
   input  logic         b_clk,
   input  logic         b_rst_n,
   output logic [N-1:0] b_pulse
);

   logic [N-1:0] tgl_q;
   logic [N-1:0] tgl_b;
   logic [N-1:0] prev_q;

   // slow side: each strobe flips its channel toggle
   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) tgl_q <= '0;
      else          tgl_q <= tgl_q ^ s_stb;
   end

   rtc_sync #(.STAGES(STAGES), .WIDTH(N)) u_sync (
      .clk   (b_clk),
      .rst_n (b_rst_n),
      .d     (tgl_q),
      .q     (tgl_b)
   );

   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) prev_q <= '0;
      else          prev_q <= tgl_b;
   end

   generate
      for (genvar c = 0; c < N; c++) begin : g_edge
         assign b_pulse[c] = tgl_b[c] ^ prev_q[c];
      end
   endgenerate

endmodule

// File: rtl/rtc_ctl_xfer.sv
module rtc_ctl_xfer #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         b_clk,
   input  logic         b_rst_n,
   input  logic         chg,
   input  logic [W-1:0] live,
   output logic         launch,
   output logic         busy,
   input  logic         s_clk,
   input  logic         s_rst_n,
   output logic [W-1:0] s_data,
   output logic         s_cap
);

   logic         pend_q;
   logic         outst_q;
   logic         req_q;
   logic         ack_seen_q;
   logic [W-1:0] hold_q;
   logic         ack_b;
   logic         done;
   logic         req_s;
   logic         seen_s_q;
   logic         new_s;

   assign launch = pend_q & ~outst_q;
   assign done   = ack_b ^ ack_seen_q;
   assign busy   = pend_q | outst_q;

   // bus side: pending change, one transfer in flight at a time
   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         pend_q     <= 1'b1;
         outst_q    <= 1'b0;
         req_q      <= 1'b0;
         ack_seen_q <= 1'b0;
         hold_q     <= '0;
      end else begin
         pend_q <= chg | (pend_q & ~launch);
         if (launch) begin
            hold_q  <= live;
            req_q   <= ~req_q;
            outst_q <= 1'b1;
         end else if (done) begin
            outst_q <= 1'b0;
         end
         if (done) ack_seen_q <= ack_b;
      end
   end

   rtc_sync #(.STAGES(STAGES), .WIDTH(1)) u_req_sync (
      .clk   (s_clk),
      .rst_n (s_rst_n),
      .d     (req_q),
      .q     (req_s)
   );

   assign new_s = req_s ^ seen_s_q;

   // slow side: take the frozen hold register, echo the toggle back
   always_ff @(posedge s_clk or negedge s_rst_n) begin
      if (!s_rst_n) begin
         seen_s_q <= 1'b0;
         s_data   <= '0;
         s_cap    <= 1'b0;
      end else begin
         s_cap <= new_s;
         if (new_s) begin
            s_data   <= hold_q;
            seen_s_q <= req_s;
         end
      end
   end

   rtc_sync #(.STAGES(STAGES), .WIDTH(1)) u_ack_sync (
      .clk   (b_clk),
      .rst_n (b_rst_n),
      .d     (seen_s_q),
      .q     (ack_b)
   );

endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
   import rtc_ctl_pkg::*;
#(
   parameter int TRIM_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [1:0]         sel,
   input  logic [WORD_W-1:0]  wdata,
   output logic [WORD_W-1:0]  rdata,
   input  logic [N_EV-1:0]    ev,
   input  logic               busy,
   input  logic               launch,
   output rtc_ctrl_t          ctrl_q,
   output logic [TRIM_W-1:0]  trim_q,
   output logic               cnt_pend_q,
   output logic               chg,
   output logic               irq_rdy,
   output logic               irq_alarm
);

   logic wr_ctrl;
   logic wr_trim;
   logic wr_cnt;
   logic trim_ok;
   logic en_chg;

   assign wr_ctrl = wr && (sel == SEL_CTRL);
   assign wr_trim = wr && (sel == SEL_TRIM);
   assign wr_cnt  = wr && (sel == SEL_COUNT);
   assign trim_ok = wr_trim && ctrl_q.key;

   assign en_chg = (ctrl_q.key && (wdata[B_RUN] != ctrl_q.run))
                 || (wdata[B_SUBEN] != ctrl_q.suben)
                 || (wdata[B_TODEN] != ctrl_q.toden);

   assign chg = wr_cnt || trim_ok || (wr_ctrl && en_chg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         ctrl_q.spare <= 1'b1;
         trim_q       <= '0;
         cnt_pend_q   <= 1'b0;
      end else begin
         // flags: hardware set wins over software clear
         if (ev[EV_UPD])                     ctrl_q.rdy <= 1'b1;
         else if (ev[EV_PRE])                ctrl_q.rdy <= 1'b0;
         else if (wr_ctrl && !wdata[B_RDY])  ctrl_q.rdy <= 1'b0;

         if (ev[EV_SUB])                     ctrl_q.subf <= 1'b1;
         else if (wr_ctrl && !wdata[B_SUBF]) ctrl_q.subf <= 1'b0;

         if (ev[EV_TOD])                     ctrl_q.todf <= 1'b1;
         else if (wr_ctrl && !wdata[B_TODF]) ctrl_q.todf <= 1'b0;

         if (wr_ctrl) begin
            ctrl_q.key    <= wdata[B_KEY];
            ctrl_q.sqfast <= wdata[B_SQFAST];
            ctrl_q.sqon   <= wdata[B_SQON];
            ctrl_q.rdyie  <= wdata[B_RDYIE];
            ctrl_q.suben  <= wdata[B_SUBEN];
            ctrl_q.toden  <= wdata[B_TODEN];
            if (!busy)        ctrl_q.spare <= wdata[B_SPARE];
            if (!ctrl_q.run)  ctrl_q.altck <= wdata[B_ALTCK];
            if (ctrl_q.key)   ctrl_q.run   <= wdata[B_RUN];
         end

         if (trim_ok) trim_q <= wdata[TRIM_W-1:0];

         if (wr_cnt)      cnt_pend_q <= 1'b1;
         else if (launch) cnt_pend_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_CTRL: rdata = pack_ctrl(ctrl_q, busy);
         SEL_TRIM: rdata[TRIM_W-1:0] = trim_q;
         default:  rdata = '0;
      endcase
   end

   assign irq_rdy   = ctrl_q.rdy & ctrl_q.rdyie;
   assign irq_alarm = (ctrl_q.subf & ctrl_q.suben) | (ctrl_q.todf & ctrl_q.toden);

endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
   import rtc_ctl_pkg::*;
#(
   parameter int TRIM_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              acc_wr,
   input  logic [1:0]        acc_sel,
   input  logic [15:0]       acc_wdata,
   output logic [15:0]       acc_rdata,
   output logic              irq_rdy,
   output logic              irq_alarm,
   output logic              alt_clk_sel,
   output logic              sqw_en,
   output logic              sqw_fast,
   input  logic              slow_clk,
   input  logic              slow_rst_n,
   input  logic              s_pre_upd,
   input  logic              s_upd,
   input  logic              s_sub_alarm,
   input  logic              s_tod_alarm,
   output logic              s_run,
   output logic              s_sub_en,
   output logic              s_tod_en,
   output logic [TRIM_W-1:0] s_trim,
   output logic              s_cnt_load
);

   localparam int XFER_W = TRIM_W + 4;
   localparam int X_CNT  = XFER_W - 1;

   generate
      if (TRIM_W < 1 || TRIM_W > WORD_W) begin : g_bad_trim
         $error("TRIM_W must lie between 1 and the word width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   rtc_ctrl_t          ctrl_q;
   logic [TRIM_W-1:0]  trim_q;
   logic               cnt_pend_q;
   logic               chg;
   logic               launch;
   logic               busy;
   logic [N_EV-1:0]    s_ev;
   logic [N_EV-1:0]    ev_pulse;
   logic [XFER_W-1:0]  live;
   logic [XFER_W-1:0]  s_data;
   logic               s_cap;

   assign s_ev[EV_PRE] = s_pre_upd;
   assign s_ev[EV_UPD] = s_upd;
   assign s_ev[EV_SUB] = s_sub_alarm;
   assign s_ev[EV_TOD] = s_tod_alarm;

   rtc_evt_sync #(.N(N_EV), .STAGES(SYNC_STAGES)) u_evt (
      .s_clk   (slow_clk),
      .s_rst_n (slow_rst_n),
      .s_stb   (s_ev),
      .b_clk   (bus_clk),
      .b_rst_n (bus_rst_n),
      .b_pulse (ev_pulse)
   );

   rtc_ctl_regs #(.TRIM_W(TRIM_W)) u_regs (
      .clk        (bus_clk),
      .rst_n      (bus_rst_n),
      .wr         (acc_wr),
      .sel        (acc_sel),
      .wdata      (acc_wdata),
      .rdata      (acc_rdata),
      .ev         (ev_pulse),
      .busy       (busy),
      .launch     (launch),
      .ctrl_q     (ctrl_q),
      .trim_q     (trim_q),
      .cnt_pend_q (cnt_pend_q),
      .chg        (chg),
      .irq_rdy    (irq_rdy),
      .irq_alarm  (irq_alarm)
   );

   assign live = {cnt_pend_q, trim_q, ctrl_q.toden, ctrl_q.suben, ctrl_q.run};

   rtc_ctl_xfer #(.W(XFER_W), .STAGES(SYNC_STAGES)) u_xfer (
      .b_clk   (bus_clk),
      .b_rst_n (bus_rst_n),
      .chg     (chg),
      .live    (live),
      .launch  (launch),
      .busy    (busy),
      .s_clk   (slow_clk),
      .s_rst_n (slow_rst_n),
      .s_data  (s_data),
      .s_cap   (s_cap)
   );

   assign s_run      = s_data[0];
   assign s_sub_en   = s_data[1];
   assign s_tod_en   = s_data[2];
   assign s_trim     = s_data[TRIM_W+2:3];
   assign s_cnt_load = s_cap & s_data[X_CNT];

   assign alt_clk_sel = ctrl_q.altck;
   assign sqw_en      = ctrl_q.sqon;
   assign sqw_fast    = ctrl_q.sqfast;

endmodule

// File: rtl/rtc_ctl_chk.sv
module rtc_ctl_chk
   import rtc_ctl_pkg::*;
#(
   parameter int TRIM_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [1:0]        sel,
   input logic [15:0]       rdata,
   input rtc_ctrl_t         ctrl,
   input logic [TRIM_W-1:0] trim,
   input logic              busy,
   input logic [N_EV-1:0]   ev
);

   assert_key_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CTRL && !ctrl.key) |=> $stable(ctrl.run));

   assert_key_trim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_TRIM && !ctrl.key) |=> $stable(trim));

   assert_busy_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_COUNT) |=> busy);

   assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[EV_PRE] && !ev[EV_UPD]) |=> !ctrl.rdy);

   assert_spare_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CTRL && busy) |=> $stable(ctrl.spare));

   assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTRL) |-> (rdata[12:10] == 3'b000));

   assert_altck_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CTRL && ctrl.run) |=> $stable(ctrl.altck));

endmodule

bind rtc_ctl_reg rtc_ctl_chk #(.TRIM_W(TRIM_W)) chk_i (
   .clk   (bus_clk),
   .rst_n (bus_rst_n),
   .wr    (acc_wr),
   .sel   (acc_sel),
   .rdata (acc_rdata),
   .ctrl  (ctrl_q),
   .trim  (trim_q),
   .busy  (busy),
   .ev    (ev_pulse)
);

// File: tb/rtc_ctl_reg_tb.sv
module rtc_ctl_reg_tb_top;

   localparam int TW = 8;

   logic          bus_clk = 1'b0;
   logic          slow_clk = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic          slow_rst_n = 1'b0;
   logic          acc_wr = 1'b0;
   logic [1:0]    acc_sel = 2'd0;
   logic [15:0]   acc_wdata = '0;
   logic [15:0]   acc_rdata;
   logic          irq_rdy, irq_alarm, alt_clk_sel, sqw_en, sqw_fast;
   logic          s_pre_upd = 1'b0, s_upd = 1'b0, s_sub_alarm = 1'b0, s_tod_alarm = 1'b0;
   logic          s_run, s_sub_en, s_tod_en, s_cnt_load;
   logic [TW-1:0] s_trim;

   int errors = 0;
   int checks = 0;
   int slow_edges = 0;
   int loads = 0;
   int cycles = 0;

   always #5  bus_clk  = ~bus_clk;
   always #80 slow_clk = ~slow_clk;

   rtc_ctl_reg #(.TRIM_W(TW), .SYNC_STAGES(2)) dut_i (
      .bus_clk, .bus_rst_n, .acc_wr, .acc_sel, .acc_wdata, .acc_rdata,
      .irq_rdy, .irq_alarm, .alt_clk_sel, .sqw_en, .sqw_fast,
      .slow_clk, .slow_rst_n, .s_pre_upd, .s_upd, .s_sub_alarm, .s_tod_alarm,
      .s_run, .s_sub_en, .s_tod_en, .s_trim, .s_cnt_load
   );

   always @(posedge slow_clk) slow_edges++;
   always @(negedge slow_clk) if (s_cnt_load) loads++;

   // scoreboard item: kind 0 read data, 1 irq pair, 2 bus outputs, 3 slow copy
   typedef struct {
      int    kind;
      int    exp;
      string req;
   } sb_item_t;

   sb_item_t sb_q[$];

   task automatic report(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected items and compares with the design outputs
   initial begin
      forever begin
         @(negedge bus_clk);
         #1;
         if (sb_q.size() > 0) begin
            sb_item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.kind)
               0:       act = int'(acc_rdata);
               1:       act = int'({irq_alarm, irq_rdy});
               2:       act = int'({alt_clk_sel, sqw_en, sqw_fast});
               default: act = int'({s_trim, s_tod_en, s_sub_en, s_run});
            endcase
            report(act == it.exp, it.req, act, it.exp);
         end
      end
   end

   task automatic expect_val(input int kind, input logic [1:0] sel, input int exp, input string req);
      sb_item_t it;
      @(negedge bus_clk);
      acc_sel = sel;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic bus_write(input logic [1:0] sel, input logic [15:0] data);
      @(negedge bus_clk);
      acc_wr    = 1'b1;
      acc_sel   = sel;
      acc_wdata = data;
      @(negedge bus_clk);
      acc_wr    = 1'b0;
   endtask

   task automatic wait_idle(input bit chk_min);
      int start;
      int n;
      start = slow_edges;
      n = 0;
      acc_sel = 2'd0;
      @(negedge bus_clk);
      while (acc_rdata[3] && n < 4000) begin
         @(negedge bus_clk);
         n++;
      end
      report(!acc_rdata[3], "R4 busy clears", int'(acc_rdata[3]), 0);
      if (chk_min)
         report((slow_edges - start) >= 2, "R4 busy spans two slow edges", slow_edges - start, 2);
   endtask

   task automatic slow_pulse(input int idx);
      @(negedge slow_clk);
      case (idx)
         0: s_pre_upd   = 1'b1;
         1: s_upd       = 1'b1;
         2: s_sub_alarm = 1'b1;
         default: s_tod_alarm = 1'b1;
      endcase
      @(negedge slow_clk);
      s_pre_upd = 1'b0; s_upd = 1'b0; s_sub_alarm = 1'b0; s_tod_alarm = 1'b0;
      repeat (8) @(negedge bus_clk);
   endtask

   initial begin
      forever begin
         @(posedge bus_clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      int l0;
      repeat (4) @(negedge bus_clk);
      bus_rst_n = 1'b1;
      slow_rst_n = 1'b1;

      // R1 reset state
      expect_val(0, 2'd0, 'h4008, "R1 reset control word");
      expect_val(0, 2'd1, 'h0000, "R1 reset trim");
      wait_idle(1'b1);
      expect_val(0, 2'd0, 'h4000, "R1 idle after first transfer");
      expect_val(3, 2'd0, 'h000, "R1 slow copy after reset");

      // R2 key low: run and trim protected; R3 no busy
      bus_write(2'd0, 16'h4001);
      expect_val(0, 2'd0, 'h4000, "R2 run ignored without key, R3 no busy");
      bus_write(2'd1, 16'h005A);
      expect_val(0, 2'd1, 'h0000, "R2 trim ignored without key");
      expect_val(0, 2'd0, 'h4000, "R3 rejected trim leaves busy low");

      // R2 key high: run writable; R3 busy; R4 slow copy
      bus_write(2'd0, 16'hC000);
      expect_val(0, 2'd0, 'hC000, "R2 key set");
      bus_write(2'd0, 16'hC001);
      expect_val(0, 2'd0, 'hC009, "R3 run change sets busy");
      wait_idle(1'b1);
      expect_val(3, 2'd0, 'h001, "R4 slow run copy");
      bus_write(2'd1, 16'h005A);
      expect_val(0, 2'd0, 'hC009, "R3 trim write sets busy");
      wait_idle(1'b1);
      expect_val(3, 2'd0, 'h2D1, "R4 slow trim copy");
      expect_val(0, 2'd1, 'h005A, "R2 trim written with key");

      // R8 clock select lock
      bus_write(2'd0, 16'hE001);
      expect_val(0, 2'd0, 'hC001, "R8 altck ignored while running");
      bus_write(2'd0, 16'hC000);
      wait_idle(1'b1);
      bus_write(2'd0, 16'hE000);
      expect_val(0, 2'd0, 'hE000, "R8 altck written while stopped");
      expect_val(2, 2'd0, 'h4, "R8 alt_clk_sel output");

      // R7 spare bit held while busy, reserved bits zero
      bus_write(2'd0, 16'hE001);
      bus_write(2'd0, 16'hA001);
      expect_val(0, 2'd0, 'hE009, "R7 spare bit held while busy");
      wait_idle(1'b1);
      bus_write(2'd0, 16'hFC01);
      expect_val(0, 2'd0, 'hE001, "R7 bits 12 to 10 read zero");

      // R12 square-wave bits
      bus_write(2'd0, 16'hE301);
      expect_val(0, 2'd0, 'hE301, "R12 square-wave bits");
      expect_val(2, 2'd0, 'h7, "R12 sqw outputs");
      bus_write(2'd0, 16'hE001);
      expect_val(2, 2'd0, 'h4, "R12 sqw outputs cleared");

      // R3/R4 alarm enables
      bus_write(2'd0, 16'hE007);
      expect_val(0, 2'd0, 'hE00F, "R3 alarm enable change sets busy");
      wait_idle(1'b1);
      expect_val(3, 2'd0, 'h2D7, "R4 slow alarm enables");

      // R10 count write
      l0 = loads;
      bus_write(2'd2, 16'h1234);
      expect_val(0, 2'd0, 'hE00F, "R3 count write sets busy");
      wait_idle(1'b1);
      repeat (40) @(negedge bus_clk);
      report((loads - l0) == 1, "R10 one load pulse", loads - l0, 1);
      expect_val(0, 2'd2, 'h0000, "R12 count select reads zero");

      // R5/R6 ready flag
      slow_pulse(1);
      expect_val(0, 2'd0, 'hE017, "R5 update sets ready");
      expect_val(1, 2'd0, 'h0, "R6 no irq without enable");
      bus_write(2'd0, 16'hE037);
      expect_val(0, 2'd0, 'hE037, "R5 writing one keeps ready");
      expect_val(1, 2'd0, 'h1, "R6 irq with enable");
      bus_write(2'd0, 16'hE027);
      expect_val(0, 2'd0, 'hE027, "R5 software clear");
      expect_val(1, 2'd0, 'h0, "R6 irq drops");
      slow_pulse(1);
      expect_val(1, 2'd0, 'h1, "R6 irq again");
      slow_pulse(0);
      expect_val(0, 2'd0, 'hE027, "R5 pre-update clears ready");
      expect_val(1, 2'd0, 'h0, "R6 irq after pre-update");

      // R9 alarm flags
      slow_pulse(2);
      expect_val(0, 2'd0, 'hE0A7, "R9 sub-second flag");
      expect_val(1, 2'd0, 'h2, "R9 alarm irq");
      slow_pulse(3);
      expect_val(0, 2'd0, 'hE0E7, "R9 time-of-day flag");
      bus_write(2'd0, 16'hE067);
      expect_val(0, 2'd0, 'hE067, "R9 clear sub-second keep time-of-day");
      expect_val(1, 2'd0, 'h2, "R9 irq from time-of-day");
      bus_write(2'd0, 16'hE027);
      expect_val(1, 2'd0, 'h0, "R9 irq after clear");
      bus_write(2'd0, 16'hE025);
      expect_val(0, 2'd0, 'hE02D, "R3 disabling alarm sets busy");
      wait_idle(1'b1);
      slow_pulse(3);
      expect_val(0, 2'd0, 'hE065, "R9 flag sets with enable off");
      expect_val(1, 2'd0, 'h0, "R9 no irq with enable off");
      bus_write(2'd0, 16'hE025);

      // R11 change during outstanding transfer
      bus_write(2'd0, 16'hE024);
      bus_write(2'd0, 16'hE025);
      expect_val(0, 2'd0, 'hE02D, "R11 busy after queued change");
      wait_idle(1'b1);
      expect_val(3, 2'd0, 'h2D3, "R11 slow copy at final value");

      // R2 key cleared again
      bus_write(2'd0, 16'h6025);
      bus_write(2'd0, 16'h6024);
      expect_val(0, 2'd0, 'h6025, "R2 run locked after key cleared");
      bus_write(2'd1, 16'h0033);
      expect_val(0, 2'd1, 'h005A, "R2 trim locked after key cleared");
      expect_val(3, 2'd0, 'h2D3, "R2 slow copy untouched");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule